// File: doc/BRIEF.md
# Mode-Switchable Approximate Multiplier with Error Correction

This block multiplies two unsigned N-bit operands with a grid of small two-bit by two-bit leaf multipliers. Each leaf is deliberately simplified: it returns a three-bit result, so the single case of three times three comes out as seven instead of nine. The leaf results are shifted to their weights and summed by an exact adder tree. All loss of accuracy therefore comes from the leaves, and every leaf can tell by itself when it has produced a wrong result.

A two-bit mode input sets how much of that loss is repaired. With no correction, the correction operand is held at zero and the raw approximate product comes out. In the top-leaf mode, only the leaf that multiplies the two highest operand digits is repaired, which costs the same small amount of logic at any width. In full mode, every leaf that detects its error pattern adds its missing two at its own weight, and the result is the exact product. The correction enable stands in for gating off the correction logic when it is not needed. A parameter selects whether the product passes through one output register or is driven combinationally.

Top module: `amul_modal`

## Requirements
- R1: A leaf returns the exact product of its two 2-bit digits, except that digits 3 and 3 give 7. A leaf signals an error exactly when all four of its operand bits are 1.
- R2: With mode 00 the product equals the sum over all leaves (A digit i, X digit j, each digit being bits 2k+1:2k) of the leaf result shifted left by 2(i+j) bits.
- R3: With mode 01 the product equals the mode 00 result plus 2·4^(2D−2), where D = N/2, when the top digits of both A and X are 3, and it equals the mode 00 result otherwise.
- R4: With mode 10 the product equals A·X exactly, for every input.
- R5: Mode 11 gives the same result as mode 10.
- R6: With mode 00 the correction operand is zero, so no correction reaches the product.
- R7: With REG_OUT=1 the product appears one clock after its inputs, and a synchronous active-low reset clears it to zero. With REG_OUT=0 the product follows the inputs combinationally.
- R8: In modes 00 and 01 the product is never larger than A·X. For example, with N=8 and both operands 255, mode 00 gives 50575.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | N | Multiplicand, unsigned |
| x_in | input | N | Multiplier, unsigned |
| mode | input | 2 | 00 raw, 01 top-leaf correction, 10 or 11 full correction |
| prod | output | 2N | Product |

## Verification
The four-bit instance is driven with every operand pair in all four mode codes. This separates a leaf that errs on the wrong pattern from a mis-weighted correction, and it separates code 11 from code 10. The eight-bit instance is driven with every operand pair in full mode, so any missed leaf correction shows up against the true product. It is also driven with a dense stride of pairs in the raw and top-leaf modes, where only operands whose top digits are both 3 separate the two modes. Directed all-ones and single-leaf cases confirm the leaf substitution and that the product stays at or below the exact value.

// File: rtl/amul_pkg.sv
// Shared mode codes and weight helper for the modal approximate multiplier.
package amul_pkg;

    // Correction selection codes; code 11 is treated as full correction.
    typedef enum logic [1:0] {
        MODE_RAW     = 2'b00,
        MODE_TOP     = 2'b01,
        MODE_ALL     = 2'b10,
        MODE_ALL_ALT = 2'b11
    } corr_mode_e;

    // Bit offset of the leaf that multiplies A digit i by X digit j.
    function automatic int leaf_shift(input int i, input int j);
        return 2 * (i + j);
    endfunction

endpackage

// File: rtl/amul_leaf2.sv
// Two-bit by two-bit simplified multiplier leaf.
// Returns a 3-bit result (3x3 collapses to 7) and flags its only error pattern.
// Assumes: purely combinational, no state.
module amul_leaf2 (
    input  logic [1:0] a_dig,
    input  logic [1:0] x_dig,
    output logic [2:0] p,
    output logic       err_hit
);

    // Reduced product logic plus the all-ones detector.
    always_comb begin
        p[0]    = a_dig[0] & x_dig[0];
        p[1]    = (a_dig[1] & x_dig[0]) | (a_dig[0] & x_dig[1]);
        p[2]    = a_dig[1] & x_dig[1];
        err_hit = &{a_dig, x_dig};
    end

endmodule

// File: rtl/amul_corr.sv
// Correction word builder: turns leaf error flags into the amount to add.
// Each flagged leaf that the mode enables contributes 2 at its own weight.
// Assumes: flag index k = i*D + j, with i the A digit and j the X digit.
module amul_corr
    import amul_pkg::*;
#(
    parameter int D = 4,
    parameter int W = 16
) (
    input  logic [D*D-1:0] hit,
    input  logic [1:0]     mode,
    output logic [W-1:0]   corr
);

    localparam int L = D * D;
    localparam logic [L-1:0] TOP_MASK = L'(1) << (L - 1);

    corr_mode_e   mode_e;
    logic [L-1:0] gated;

    // Select which detected errors may reach the adder; others are held at zero.
    always_comb begin
        mode_e = corr_mode_e'(mode);
        unique case (mode_e)
            MODE_RAW:               gated = '0;
            MODE_TOP:               gated = hit & TOP_MASK;
            MODE_ALL, MODE_ALL_ALT: gated = hit;
            default:                gated = '0;
        endcase
    end

    // Sum the +2 repairs at each enabled leaf weight.
    always_comb begin
        corr = '0;
        for (int i = 0; i < D; i++) begin
            for (int j = 0; j < D; j++) begin
                if (gated[i*D+j]) begin
                    corr = corr + (W'(2) << leaf_shift(i, j));
                end
            end
        end
    end

endmodule

// File: rtl/amul_modal.sv
// Modal approximate multiplier: a grid of simplified 2x2 leaves summed by an
// exact adder, plus a mode-selected correction term. Optional output register.
// Assumes: N even and at least 2; operands unsigned.
module amul_modal
    import amul_pkg::*;
#(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   a_in,
    input  logic [N-1:0]   x_in,
    input  logic [1:0]     mode,
    output logic [2*N-1:0] prod
);

    localparam int D = N / 2;
    localparam int W = 2 * N;
    localparam int L = D * D;
    localparam logic [W-1:0] TOP_CORR = W'(2) << (4 * (D - 1));

    logic [2:0]   leaf_p [L];
    logic [L-1:0] leaf_hit;
    logic [W-1:0] approx_sum;
    logic [W-1:0] corr;
    logic [W-1:0] prod_d;
    logic [W-1:0] exact_chk;

    // One leaf per pair of operand digits.
    for (genvar gi = 0; gi < D; gi++) begin : g_row
        for (genvar gj = 0; gj < D; gj++) begin : g_col
            amul_leaf2 u_leaf (
                .a_dig  (a_in[2*gi +: 2]),
                .x_dig  (x_in[2*gj +: 2]),
                .p      (leaf_p[gi*D+gj]),
                .err_hit(leaf_hit[gi*D+gj])
            );
        end
    end

    // Exact shifted sum of the leaf results.
    always_comb begin
        approx_sum = '0;
        for (int i = 0; i < D; i++) begin
            for (int j = 0; j < D; j++) begin
                approx_sum = approx_sum + (W'(leaf_p[i*D+j]) << leaf_shift(i, j));
            end
        end
    end

    amul_corr #(
        .D(D),
        .W(W)
    ) u_corr (
        .hit (leaf_hit),
        .mode(mode),
        .corr(corr)
    );

    // Final correcting adder.
    assign prod_d = approx_sum + corr;

    // Reference product used only by the checks below.
    assign exact_chk = W'(a_in) * W'(x_in);

    if (REG_OUT) begin : g_reg
        // Output register with synchronous active-low clear.
        always_ff @(posedge clk) begin
            if (!rst_n) prod <= '0;
            else        prod <= prod_d;
        end

        AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> prod == $past(prod_d)); // R7
    end else begin : g_comb
        assign prod = prod_d;
    end

    AST_FULL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |-> prod_d == exact_chk); // R4
    AST_RAW_NO_CORR: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_RAW |-> corr == '0); // R6
    AST_TOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_TOP |-> (corr == '0 || corr == TOP_CORR)); // R3
    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |-> prod_d <= exact_chk); // R8
    AST_LEAF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        leaf_hit[0] == (a_in[1:0] == 2'b11 && x_in[1:0] == 2'b11)); // R1

endmodule

// File: tb/sim_amul_modal.sv
`timescale 1ns / 100ps
module sim_amul_modal;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  a8, x8;
    logic [1:0]  m8;
    logic [15:0] prod8;
    logic [3:0]  a4, x4;
    logic [1:0]  m4;
    logic [7:0]  prod4;
    logic        v8, v4;

    int n_chk  = 0;
    int n_fail = 0;
    int q8 [$];
    int q4 [$];
    string t8 [$];
    string t4 [$];

    always #2.5 clk = ~clk;

    amul_modal #(.N(8), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .a_in(a8), .x_in(x8), .mode(m8), .prod(prod8));
    amul_modal #(.N(4), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .a_in(a4), .x_in(x4), .mode(m4), .prod(prod4));

    // Expected value from the requirements: leaves lose 2 on 3x3 unless repaired.
    function automatic int model(input int d, input int a, input int x, input int m);
        int res = 0;
        if (m >= 2) return a * x;
        for (int i = 0; i < d; i++) begin
            for (int j = 0; j < d; j++) begin
                int p = ((a >> (2*i)) & 3) * ((x >> (2*j)) & 3);
                if (p == 9 && !(m == 1 && i == d-1 && j == d-1)) p = 7;
                res += p << (2*(i+j));
            end
        end
        return res;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive8(input int a, input int x, input int m, input string tag, input int exp);
        @(negedge clk);
        a8 = 8'(a); x8 = 8'(x); m8 = 2'(m); v8 = 1'b1; v4 = 1'b0;
        q8.push_back(exp); t8.push_back(tag);
    endtask

    task automatic drive4(input int a, input int x, input int m, input string tag, input int exp);
        @(negedge clk);
        a4 = 4'(a); x4 = 4'(x); m4 = 2'(m); v4 = 1'b1; v8 = 1'b0;
        q4.push_back(exp); t4.push_back(tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Monitor: at each edge note which items the design captured, compare after it.
    always @(posedge clk) begin
        bit p8, p4;
        p8 = v8; p4 = v4;
        #1;
        if (p8) check(t8.pop_front(), int'(prod8), q8.pop_front());
        if (p4) check(t4.pop_front(), int'(prod4), q4.pop_front());
    end

    // Driver.
    initial begin
        string tg;
        rst_n = 1'b0; a8 = '0; x8 = '0; m8 = '0; a4 = '0; x4 = '0; m4 = '0;
        v8 = 1'b0; v4 = 1'b0;
        a8 = 8'hFF; x8 = 8'hFF; m8 = 2'b10;
        repeat (3) @(negedge clk);
        check("R7 reset clears product", int'(prod8), 0);
        rst_n = 1'b1;

        // R1 single-leaf cases at the lowest and a middle digit.
        drive4(3, 3, 0, "R1 leaf 3x3 gives 7", 7);
        drive4(2, 3, 0, "R1 leaf 2x3 exact", 6);
        drive4(12, 3, 0, "R1 leaf weight 4", 28);

        // Full sweep of the 4-bit instance in every mode code (combinational path).
        for (int m = 0; m < 4; m++) begin
            tg = (m == 0) ? "R2 raw" : (m == 1) ? "R3 top" : (m == 2) ? "R4 full" : "R5 code11";
            for (int a = 0; a < 16; a++)
                for (int x = 0; x < 16; x++)
                    drive4(a, x, m, {tg, " R7 comb"}, model(2, a, x, m));
        end

        // Full-mode sweep of the 8-bit instance against the true product.
        for (int a = 0; a < 256; a++)
            for (int x = 0; x < 256; x++)
                drive8(a, x, 2, "R4 full exact", a * x);

        // Strided sweeps of raw, top-leaf and code 11 on the 8-bit instance.
        for (int a = 0; a < 256; a++)
            for (int x = 0; x < 256; x += 3) begin
                drive8(a, x, 0, "R2 raw", model(4, a, x, 0));
                drive8(a, x, 1, "R3 top", model(4, a, x, 1));
            end
        for (int a = 0; a < 256; a += 5)
            for (int x = 0; x < 256; x += 7)
                drive8(a, x, 3, "R5 code11 exact", a * x);

        // Directed corners.
        drive8(255, 255, 0, "R8 raw all-ones below exact", 50575);
        drive8(255, 255, 1, "R8 top all-ones below exact", 58767);
        drive8(255, 255, 3, "R5 all-ones code11", 65025);
        drive8(192, 192, 1, "R3 only top leaf fixed", 36864);
        drive8(3, 3, 1, "R3 low leaf not fixed", 7);

        @(negedge clk);
        v8 = 1'b0; v4 = 1'b0;
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual 0 expected 1");
        summary();
        $finish;
    end

endmodule